// File: doc/BRIEF.md
# Exception Entry Control Sequencer

This block works out how a processor's control registers change when an exception is taken. When the exception strobe is raised, the block reads the cause code, the current PC, the faulting address, the two handler vectors and the present contents of the control registers. It then produces the post-entry values of status, the saved-status pair for ordinary exceptions (estatus and EA), the saved-status pair for breaks (bstatus and BA), the exception cause register, the TLB-miscellaneous flags, the bad-address register and the next PC.

The saving rules depend on whether a handler is already running, which the exception-handling (EH) bit of the incoming status shows. Nested traps, supervisor faults, breaks and unaligned accesses therefore keep the outer handler's return state. A TLB miss is sent to a dedicated fast vector when EH is clear. When EH is already set it is flagged as a double miss and sent to the general vector. All results are registered and appear together one clock edge after the strobe, with a one-cycle commit pulse. An unknown cause code produces a one-cycle error pulse instead.

Top module: `exc_entry_seq`

## Requirements
- R1: On a recognised exception, status_o equals status_i with bit 0 (previous interrupt enable) and bit 1 (user mode) cleared. It also has bit 3 (interrupt-handling) set for cause 2 (external interrupt), or bit 2 (EH) set for every other recognised cause. All other status bits are kept.
- R2: For every recognised cause except unaligned access (cause 6), exc_o equals exc_i with bits 6:2 replaced by the 5-bit cause code.
- R3: An external interrupt (cause 2) loads estatus_o with status_i and ea_o with pc_i+4, and sets pc_o to gen_vec_i.
- R4: A TLB miss (cause 12) with EH clear in status_i loads estatus_o with status_i and ea_o with pc_i+4. It clears the double-miss flag (tlbmisc bit 1), sets the write flag (tlbmisc bit 0) and sets pc_o to fast_vec_i.
- R5: A TLB miss (cause 12) with EH set in status_i leaves estatus, EA and the write flag unchanged, sets the double-miss flag (tlbmisc bit 1) and sets pc_o to gen_vec_i.
- R6: Trap (3), illegal instruction (5), unaligned access (6), supervisor-instruction (9), supervisor-address (10) and supervisor-data (11) exceptions load estatus_o with status_i and ea_o with pc_i+4 only when EH was clear in status_i. In every case they set pc_o to gen_vec_i.
- R7: A break (cause 7) loads bstatus_o with status_i and ba_o with pc_i+4 only when EH was clear in status_i. Estatus and EA are never touched by a break, and pc_o becomes gen_vec_i.
- R8: Permission faults (13 execute, 14 read, 15 write) always load estatus_o with status_i and ea_o with pc_i+4, and set pc_o to gen_vec_i. They set the tlbmisc write flag (bit 0) only when EH was clear in status_i before entry.
- R9: An unaligned access (cause 6) loads badaddr_o with fault_addr_i and overwrites all of exc_o with the cause shifted left by two. Every other cause leaves badaddr unchanged.
- R10: Only causes 2, 3, 5, 6, 7, 9 to 15 are recognised. Any other cause gives outputs equal to the current register inputs, err_o high for one cycle and commit_o low.
- R11: All outputs change together on the clock edge after exc_valid_i is sampled high. commit_o pulses for that one cycle on a recognised cause. Without a strobe, all outputs hold and both pulses stay low.
- R12: A synchronous reset (rst high) clears every output to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| exc_valid_i | input | 1 | Exception taken this cycle |
| cause_i | input | 5 | Exception cause code |
| pc_i | input | XLEN | PC of the excepting instruction |
| fault_addr_i | input | XLEN | Faulting data address |
| gen_vec_i | input | XLEN | General exception vector |
| fast_vec_i | input | XLEN | Fast TLB-miss vector |
| status_i | input | XLEN | Current status |
| estatus_i | input | XLEN | Current estatus |
| bstatus_i | input | XLEN | Current bstatus |
| exc_i | input | XLEN | Current exception cause register |
| tlbmisc_i | input | XLEN | Current TLB-miscellaneous register |
| badaddr_i | input | XLEN | Current bad-address register |
| ea_i | input | XLEN | Current exception return address |
| ba_i | input | XLEN | Current break return address |
| status_o | output | XLEN | Next status |
| estatus_o | output | XLEN | Next estatus |
| bstatus_o | output | XLEN | Next bstatus |
| exc_o | output | XLEN | Next exception cause register |
| tlbmisc_o | output | XLEN | Next TLB-miscellaneous register |
| badaddr_o | output | XLEN | Next bad-address register |
| ea_o | output | XLEN | Next exception return address |
| ba_o | output | XLEN | Next break return address |
| pc_o | output | XLEN | Next PC |
| commit_o | output | 1 | One-cycle pulse: new values valid |
| err_o | output | 1 | One-cycle pulse: unknown cause |

## Verification
Every result of this block, including the commit and error pulses, is due exactly one rising edge after exc_valid_i is sampled high. The pulses drop on the edge after that. The bench changes inputs on the falling edge and raises the strobe for a single cycle. It compares all eleven outputs on the next falling edge, and compares them again one cycle later to confirm that they held and that both pulses fell. Each sweep covers all 32 cause codes against several status patterns, with EH both clear and set, so the nested and non-nested save rules are both reached for each class.

// File: rtl/exc_entry_pkg.sv
package exc_entry_pkg;

    localparam int CAUSE_W   = 5;
    localparam int CAUSE_LSB = 2;

    // status bit positions
    localparam int ST_PIE = 0;
    localparam int ST_U   = 1;
    localparam int ST_EH  = 2;
    localparam int ST_IH  = 3;

    // TLB-misc flag positions
    localparam int TM_WR  = 0;
    localparam int TM_DBL = 1;

    // cause codes
    localparam logic [CAUSE_W-1:0] C_IRQ      = 5'd2;
    localparam logic [CAUSE_W-1:0] C_TRAP     = 5'd3;
    localparam logic [CAUSE_W-1:0] C_ILLEGAL  = 5'd5;
    localparam logic [CAUSE_W-1:0] C_UNALIGN  = 5'd6;
    localparam logic [CAUSE_W-1:0] C_BREAK    = 5'd7;
    localparam logic [CAUSE_W-1:0] C_SUP_INSN = 5'd9;
    localparam logic [CAUSE_W-1:0] C_SUP_ADDR = 5'd10;
    localparam logic [CAUSE_W-1:0] C_SUP_DATA = 5'd11;
    localparam logic [CAUSE_W-1:0] C_TLB_MISS = 5'd12;
    localparam logic [CAUSE_W-1:0] C_PERM_X   = 5'd13;
    localparam logic [CAUSE_W-1:0] C_PERM_R   = 5'd14;
    localparam logic [CAUSE_W-1:0] C_PERM_W   = 5'd15;

    typedef enum logic [2:0] {
        CL_NONE,
        CL_IRQ,
        CL_TLBMISS,
        CL_PERM,
        CL_SOFT,
        CL_UNALIGN,
        CL_BREAK
    } exc_class_e;

    // per-entry action plan produced by the decoder
    typedef struct packed {
        logic known;
        logic set_ih;
        logic save_e;
        logic save_b;
        logic to_fast;
        logic set_wr;
        logic set_dbl;
        logic clr_dbl;
        logic load_bad;
        logic full_exc;
    } entry_plan_t;

    function automatic exc_class_e classify(input logic [CAUSE_W-1:0] c);
        exc_class_e r;
        case (c)
            C_IRQ:                              r = CL_IRQ;
            C_TLB_MISS:                         r = CL_TLBMISS;
            C_PERM_X, C_PERM_R, C_PERM_W:       r = CL_PERM;
            C_TRAP, C_ILLEGAL,
            C_SUP_INSN, C_SUP_ADDR, C_SUP_DATA: r = CL_SOFT;
            C_UNALIGN:                          r = CL_UNALIGN;
            C_BREAK:                            r = CL_BREAK;
            default:                            r = CL_NONE;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/exc_entry_decode.sv
module exc_entry_decode
    import exc_entry_pkg::*;
(
    input  logic [CAUSE_W-1:0] cause_i,
    input  logic               eh_i,
    output entry_plan_t        plan_o
);

    exc_class_e cls;

    assign cls = classify(cause_i);

    always_comb begin
        plan_o       = '0;
        plan_o.known = (cls != CL_NONE);
        unique case (cls)
            CL_IRQ: begin
                plan_o.save_e = 1'b1;
                plan_o.set_ih = 1'b1;
            end
            CL_TLBMISS: begin
                if (!eh_i) begin
                    plan_o.save_e  = 1'b1;
                    plan_o.to_fast = 1'b1;
                    plan_o.clr_dbl = 1'b1;
                    plan_o.set_wr  = 1'b1;
                end else begin
                    plan_o.set_dbl = 1'b1;
                end
            end
            CL_PERM: begin
                plan_o.save_e = 1'b1;
                plan_o.set_wr = !eh_i;
            end
            CL_SOFT: begin
                plan_o.save_e = !eh_i;
            end
            CL_UNALIGN: begin
                plan_o.save_e   = !eh_i;
                plan_o.load_bad = 1'b1;
                plan_o.full_exc = 1'b1;
            end
            CL_BREAK: begin
                plan_o.save_b = !eh_i;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/exc_entry_update.sv
module exc_entry_update
    import exc_entry_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  entry_plan_t        plan_i,
    input  logic [CAUSE_W-1:0] cause_i,
    input  logic [XLEN-1:0]    pc_i,
    input  logic [XLEN-1:0]    fault_addr_i,
    input  logic [XLEN-1:0]    gen_vec_i,
    input  logic [XLEN-1:0]    fast_vec_i,
    input  logic [XLEN-1:0]    status_i,
    input  logic [XLEN-1:0]    estatus_i,
    input  logic [XLEN-1:0]    bstatus_i,
    input  logic [XLEN-1:0]    exc_i,
    input  logic [XLEN-1:0]    tlbmisc_i,
    input  logic [XLEN-1:0]    badaddr_i,
    input  logic [XLEN-1:0]    ea_i,
    input  logic [XLEN-1:0]    ba_i,
    output logic [XLEN-1:0]    status_n,
    output logic [XLEN-1:0]    estatus_n,
    output logic [XLEN-1:0]    bstatus_n,
    output logic [XLEN-1:0]    exc_n,
    output logic [XLEN-1:0]    tlbmisc_n,
    output logic [XLEN-1:0]    badaddr_n,
    output logic [XLEN-1:0]    ea_n,
    output logic [XLEN-1:0]    ba_n,
    output logic [XLEN-1:0]    pc_n
);

    localparam logic [XLEN-1:0] INSN_BYTES = XLEN'(4);

    logic [XLEN-1:0] ret_addr;

    assign ret_addr = pc_i + INSN_BYTES;

    always_comb begin
        status_n  = status_i;
        estatus_n = estatus_i;
        bstatus_n = bstatus_i;
        exc_n     = exc_i;
        tlbmisc_n = tlbmisc_i;
        badaddr_n = badaddr_i;
        ea_n      = ea_i;
        ba_n      = ba_i;
        pc_n      = pc_i;

        if (plan_i.known) begin
            status_n[ST_PIE] = 1'b0;
            status_n[ST_U]   = 1'b0;
            if (plan_i.set_ih) status_n[ST_IH] = 1'b1;
            else               status_n[ST_EH] = 1'b1;

            if (plan_i.full_exc)
                exc_n = XLEN'(cause_i) << CAUSE_LSB;
            else
                exc_n[CAUSE_LSB +: CAUSE_W] = cause_i;

            if (plan_i.save_e) begin
                estatus_n = status_i;
                ea_n      = ret_addr;
            end
            if (plan_i.save_b) begin
                bstatus_n = status_i;
                ba_n      = ret_addr;
            end

            if (plan_i.clr_dbl) tlbmisc_n[TM_DBL] = 1'b0;
            if (plan_i.set_dbl) tlbmisc_n[TM_DBL] = 1'b1;
            if (plan_i.set_wr)  tlbmisc_n[TM_WR]  = 1'b1;

            if (plan_i.load_bad) badaddr_n = fault_addr_i;

            pc_n = plan_i.to_fast ? fast_vec_i : gen_vec_i;
        end
    end

endmodule

// File: rtl/exc_entry_seq.sv
module exc_entry_seq
    import exc_entry_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               exc_valid_i,
    input  logic [CAUSE_W-1:0] cause_i,
    input  logic [XLEN-1:0]    pc_i,
    input  logic [XLEN-1:0]    fault_addr_i,
    input  logic [XLEN-1:0]    gen_vec_i,
    input  logic [XLEN-1:0]    fast_vec_i,
    input  logic [XLEN-1:0]    status_i,
    input  logic [XLEN-1:0]    estatus_i,
    input  logic [XLEN-1:0]    bstatus_i,
    input  logic [XLEN-1:0]    exc_i,
    input  logic [XLEN-1:0]    tlbmisc_i,
    input  logic [XLEN-1:0]    badaddr_i,
    input  logic [XLEN-1:0]    ea_i,
    input  logic [XLEN-1:0]    ba_i,
    output logic [XLEN-1:0]    status_o,
    output logic [XLEN-1:0]    estatus_o,
    output logic [XLEN-1:0]    bstatus_o,
    output logic [XLEN-1:0]    exc_o,
    output logic [XLEN-1:0]    tlbmisc_o,
    output logic [XLEN-1:0]    badaddr_o,
    output logic [XLEN-1:0]    ea_o,
    output logic [XLEN-1:0]    ba_o,
    output logic [XLEN-1:0]    pc_o,
    output logic               commit_o,
    output logic               err_o
);

    entry_plan_t     plan;
    logic [XLEN-1:0] status_n, estatus_n, bstatus_n, exc_n, tlbmisc_n;
    logic [XLEN-1:0] badaddr_n, ea_n, ba_n, pc_n;

    exc_entry_decode u_decode (
        .cause_i (cause_i),
        .eh_i    (status_i[ST_EH]),
        .plan_o  (plan)
    );

    exc_entry_update #(.XLEN(XLEN)) u_update (
        .plan_i       (plan),
        .cause_i      (cause_i),
        .pc_i         (pc_i),
        .fault_addr_i (fault_addr_i),
        .gen_vec_i    (gen_vec_i),
        .fast_vec_i   (fast_vec_i),
        .status_i     (status_i),
        .estatus_i    (estatus_i),
        .bstatus_i    (bstatus_i),
        .exc_i        (exc_i),
        .tlbmisc_i    (tlbmisc_i),
        .badaddr_i    (badaddr_i),
        .ea_i         (ea_i),
        .ba_i         (ba_i),
        .status_n     (status_n),
        .estatus_n    (estatus_n),
        .bstatus_n    (bstatus_n),
        .exc_n        (exc_n),
        .tlbmisc_n    (tlbmisc_n),
        .badaddr_n    (badaddr_n),
        .ea_n         (ea_n),
        .ba_n         (ba_n),
        .pc_n         (pc_n)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            status_o  <= '0;
            estatus_o <= '0;
            bstatus_o <= '0;
            exc_o     <= '0;
            tlbmisc_o <= '0;
            badaddr_o <= '0;
            ea_o      <= '0;
            ba_o      <= '0;
            pc_o      <= '0;
            commit_o  <= 1'b0;
            err_o     <= 1'b0;
        end else begin
            commit_o <= exc_valid_i && plan.known;
            err_o    <= exc_valid_i && !plan.known;
            if (exc_valid_i) begin
                status_o  <= status_n;
                estatus_o <= estatus_n;
                bstatus_o <= bstatus_n;
                exc_o     <= exc_n;
                tlbmisc_o <= tlbmisc_n;
                badaddr_o <= badaddr_n;
                ea_o      <= ea_n;
                ba_o      <= ba_n;
                pc_o      <= pc_n;
            end
        end
    end

endmodule

// File: rtl/exc_entry_checker.sv
module exc_entry_checker
    import exc_entry_pkg::*;
#(
    parameter int XLEN = 32
) (
    input logic               clk,
    input logic               rst,
    input logic               exc_valid_i,
    input logic [CAUSE_W-1:0] cause_i,
    input logic [XLEN-1:0]    pc_i,
    input logic [XLEN-1:0]    fast_vec_i,
    input logic [XLEN-1:0]    status_i,
    input logic [XLEN-1:0]    estatus_i,
    input logic [XLEN-1:0]    status_o,
    input logic [XLEN-1:0]    estatus_o,
    input logic [XLEN-1:0]    exc_o,
    input logic [XLEN-1:0]    pc_o,
    input logic               commit_o,
    input logic               err_o
);

    assert_pulses_exclusive_R11: assert property (@(posedge clk) disable iff (rst)
        !(commit_o && err_o));

    assert_status_entry_R1: assert property (@(posedge clk) disable iff (rst)
        commit_o |-> (!status_o[ST_PIE] && !status_o[ST_U] &&
                      (status_o[ST_EH] || status_o[ST_IH])));

    assert_cause_field_R2: assert property (@(posedge clk) disable iff (rst)
        commit_o |-> (exc_o[CAUSE_LSB +: CAUSE_W] == $past(cause_i)));

    assert_fast_vector_R4: assert property (@(posedge clk) disable iff (rst)
        (commit_o && $past(cause_i) == C_TLB_MISS && !$past(status_i[ST_EH]))
            |-> (pc_o == $past(fast_vec_i)));

    assert_break_keeps_estatus_R7: assert property (@(posedge clk) disable iff (rst)
        (commit_o && $past(cause_i) == C_BREAK) |-> (estatus_o == $past(estatus_i)));

    assert_unknown_unchanged_R10: assert property (@(posedge clk) disable iff (rst)
        err_o |-> (pc_o == $past(pc_i) && status_o == $past(status_i)));

    assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (rst)
        !exc_valid_i |=> (!commit_o && !err_o && $stable(pc_o) && $stable(status_o)));

endmodule

bind exc_entry_seq exc_entry_checker #(.XLEN(XLEN)) u_checker (
    .clk         (clk),
    .rst         (rst),
    .exc_valid_i (exc_valid_i),
    .cause_i     (cause_i),
    .pc_i        (pc_i),
    .fast_vec_i  (fast_vec_i),
    .status_i    (status_i),
    .estatus_i   (estatus_i),
    .status_o    (status_o),
    .estatus_o   (estatus_o),
    .exc_o       (exc_o),
    .pc_o        (pc_o),
    .commit_o    (commit_o),
    .err_o       (err_o)
);

// File: tb/sim_exc_entry_seq.sv
`timescale 1ns/1ps
module sim_exc_entry_seq;

    localparam int XLEN = 32;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            exc_valid_i = 1'b0;
    logic [4:0]      cause_i = '0;
    logic [XLEN-1:0] pc_i = '0, fault_addr_i = '0, gen_vec_i = '0, fast_vec_i = '0;
    logic [XLEN-1:0] status_i = '0, estatus_i = '0, bstatus_i = '0, exc_i = '0;
    logic [XLEN-1:0] tlbmisc_i = '0, badaddr_i = '0, ea_i = '0, ba_i = '0;
    logic [XLEN-1:0] status_o, estatus_o, bstatus_o, exc_o, tlbmisc_o;
    logic [XLEN-1:0] badaddr_o, ea_o, ba_o, pc_o;
    logic            commit_o, err_o;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    // expected values
    logic [XLEN-1:0] x_st, x_es, x_bs, x_exc, x_tm, x_bad, x_ea, x_ba, x_pc;
    logic            x_commit, x_err;
    string           r_save;

    always #2.5 clk = ~clk;

    exc_entry_seq #(.XLEN(XLEN)) u0 (
        .clk(clk), .rst(rst), .exc_valid_i(exc_valid_i), .cause_i(cause_i),
        .pc_i(pc_i), .fault_addr_i(fault_addr_i), .gen_vec_i(gen_vec_i),
        .fast_vec_i(fast_vec_i), .status_i(status_i), .estatus_i(estatus_i),
        .bstatus_i(bstatus_i), .exc_i(exc_i), .tlbmisc_i(tlbmisc_i),
        .badaddr_i(badaddr_i), .ea_i(ea_i), .ba_i(ba_i),
        .status_o(status_o), .estatus_o(estatus_o), .bstatus_o(bstatus_o),
        .exc_o(exc_o), .tlbmisc_o(tlbmisc_o), .badaddr_o(badaddr_o),
        .ea_o(ea_o), .ba_o(ba_o), .pc_o(pc_o), .commit_o(commit_o), .err_o(err_o)
    );

    task automatic chk(input string req, input string fld,
                       input logic [XLEN-1:0] act, input logic [XLEN-1:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s cause=%0d st=%h: actual %h expected %h",
                     req, fld, cause_i, status_i, act, exp);
        end
    endtask

    function automatic logic [XLEN-1:0] status_pat(input int k);
        case (k)
            0: return 32'h0000_0003;   // EH clear, PIE and U set
            1: return 32'h0000_0007;   // EH set
            2: return 32'hF0F0_00F1;   // EH clear, upper bits busy
            default: return 32'hA5A5_A5AE; // EH and IH set
        endcase
    endfunction

    // reference model from the requirements
    task automatic model();
        logic eh;
        logic known;
        logic [XLEN-1:0] ret;
        eh  = status_i[2];
        ret = pc_i + 32'd4;
        known = (cause_i == 2) || (cause_i == 3) || (cause_i == 5) ||
                (cause_i == 6) || (cause_i == 7) ||
                (cause_i >= 9 && cause_i <= 15);
        x_st = status_i; x_es = estatus_i; x_bs = bstatus_i; x_exc = exc_i;
        x_tm = tlbmisc_i; x_bad = badaddr_i; x_ea = ea_i; x_ba = ba_i; x_pc = pc_i;
        x_commit = known; x_err = !known;
        r_save = "R10";
        if (known) begin
            x_st = status_i & ~32'h3;
            x_st = x_st | ((cause_i == 2) ? 32'h8 : 32'h4);
            x_exc = (exc_i & ~32'h7C) | (32'(cause_i) * 4);
            x_pc = gen_vec_i;
            if (cause_i == 2) begin
                r_save = "R3";
                x_es = status_i; x_ea = ret;
            end else if (cause_i == 12) begin
                if (!eh) begin
                    r_save = "R4";
                    x_es = status_i; x_ea = ret;
                    x_tm = (tlbmisc_i & ~32'h2) | 32'h1;
                    x_pc = fast_vec_i;
                end else begin
                    r_save = "R5";
                    x_tm = tlbmisc_i | 32'h2;
                end
            end else if (cause_i >= 13) begin
                r_save = "R8";
                x_es = status_i; x_ea = ret;
                if (!eh) x_tm = tlbmisc_i | 32'h1;
            end else if (cause_i == 7) begin
                r_save = "R7";
                if (!eh) begin x_bs = status_i; x_ba = ret; end
            end else begin
                r_save = "R6";
                if (!eh) begin x_es = status_i; x_ea = ret; end
                if (cause_i == 6) begin
                    x_bad = fault_addr_i;
                    x_exc = 32'(cause_i) * 4;
                end
            end
        end
    endtask

    task automatic run_one(input int c, input int k);
        logic [XLEN-1:0] hold_pc, hold_st;
        string r_st, r_exc;
        @(negedge clk);
        cause_i      = 5'(c);
        status_i     = status_pat(k);
        pc_i         = 32'h1000_0000 + 32'(c * 64 + k * 8);
        fault_addr_i = 32'h8000_0001 ^ 32'(c * 4099 + k);
        gen_vec_i    = 32'h0000_0120 + 32'(k * 16);
        fast_vec_i   = 32'h0000_0400 + 32'(c * 4);
        estatus_i    = 32'h1111_0000 + 32'(c);
        bstatus_i    = 32'h2222_0000 + 32'(k);
        exc_i        = 32'hFFFF_FF83 ^ 32'(k << 8);
        tlbmisc_i    = (k[0]) ? 32'h0000_00F2 : 32'h0000_0F00;
        badaddr_i    = 32'h3333_0000 + 32'(c);
        ea_i         = 32'h4444_0000 + 32'(k);
        ba_i         = 32'h5555_0000 + 32'(c);
        exc_valid_i  = 1'b1;
        model();
        @(negedge clk);
        exc_valid_i = 1'b0;
        r_st  = x_commit ? "R1" : "R10";
        r_exc = (!x_commit) ? "R10" : ((c == 6) ? "R9" : "R2");
        chk(r_st,   "status",  status_o,  x_st);
        chk(r_exc,  "exc",     exc_o,     x_exc);
        chk(r_save, "estatus", estatus_o, x_es);
        chk(r_save, "bstatus", bstatus_o, x_bs);
        chk(r_save, "ea",      ea_o,      x_ea);
        chk(r_save, "ba",      ba_o,      x_ba);
        chk(r_save, "tlbmisc", tlbmisc_o, x_tm);
        chk(r_save, "pc",      pc_o,      x_pc);
        chk(x_commit ? "R9" : "R10", "badaddr", badaddr_o, x_bad);
        chk("R11", "commit", {31'b0, commit_o}, {31'b0, x_commit});
        chk("R10", "err",    {31'b0, err_o},    {31'b0, x_err});
        hold_pc = pc_o;
        hold_st = status_o;
        @(negedge clk);
        chk("R11", "commit_fall", {31'b0, commit_o}, 32'd0);
        chk("R10", "err_fall",    {31'b0, err_o},    32'd0);
        chk("R11", "pc_hold",     pc_o,     hold_pc);
        chk("R11", "status_hold", status_o, hold_st);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R12: reset state, still in reset
        chk("R12", "status",  status_o,  '0);
        chk("R12", "estatus", estatus_o, '0);
        chk("R12", "bstatus", bstatus_o, '0);
        chk("R12", "exc",     exc_o,     '0);
        chk("R12", "tlbmisc", tlbmisc_o, '0);
        chk("R12", "badaddr", badaddr_o, '0);
        chk("R12", "ea",      ea_o,      '0);
        chk("R12", "ba",      ba_o,      '0);
        chk("R12", "pc",      pc_o,      '0);
        chk("R12", "pulses",  {30'b0, commit_o, err_o}, '0);
        rst = 1'b0;
        for (int k = 0; k < 4; k++) begin
            for (int c = 0; c < 32; c++) begin
                run_one(c, k);
            end
        end
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #100000;
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: run did not finish, actual hung expected done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule